// File: doc/BRIEF.md
# Plug-and-play configuration port controller

This block is the host-facing configuration window of a multi-function I/O controller. Two adjacent I/O addresses form the window: the lower address is an index port that chooses a configuration register, and the upper address is a data port that reads or writes the chosen register. The window is normally closed. The host opens it by writing an entry key to the index port and closes it again with an exit key.

While the window is open, the host first writes a logical device number to a global selector register. The activate, base-address and interrupt registers then refer to the register bank of that device. Every bank is also driven out on parallel output buses, so that an address decoder and the device logic can use the programmed values directly. Device numbers that have no bank read back as all ones on their banked registers, and writes to them are discarded.

The window is controlled by a two-state machine. The states are `CFG_LOCKED` (the reset state) and `CFG_OPEN`. The transition `KEY_ENTER` goes from `CFG_LOCKED` to `CFG_OPEN` when 0x55 is written to the index port. The transition `KEY_EXIT` goes from `CFG_OPEN` to `CFG_LOCKED` when 0xAA is written to the index port. Every other input holds the current state.

Top module: `pnpcfg_port`

## Requirements
- R1: After reset the window is in `CFG_LOCKED`, the index and device-number registers are 0x00, and every bank is inactive with both base addresses and the interrupt select at zero on the output buses.
- R2: The index port is at address `PORT_BASE` (default 0x2E) and the data port is at `PORT_BASE`+1. Writing 0x55 to the index port while locked opens the window. Writing 0xAA to the index port while open locks it. Neither key value is stored as an index.
- R3: While locked, data-port writes change nothing, reads of either port return 0xFF, and index-port writes other than 0x55 leave the stored index unchanged.
- R4: Index 0x07 is the logical device number register. It is 8 bits wide, and it can be read and written through the data port while the window is open.
- R5: Index 0x30 is the activate register of the selected device. A write stores data bit 0 (1 enables, 0 disables). A read returns 0x01 or 0x00, and the value appears on bit n of `dev_active` for device n.
- R6: Index 0x60 holds the high byte and index 0x61 the low byte of base address 0. Index 0x62 holds the high byte and index 0x63 the low byte of base address 1. Device n drives bits [16n+15:16n] of `dev_base0` and `dev_base1`.
- R7: Index 0x70 is the interrupt select of the selected device. It is 8 bits wide, can be read back, and device n drives bits [8n+7:8n] of `dev_irq`.
- R8: Devices 1, 2, 3, 4, 7, 8 and 9 have banks (`IMPL_MASK` = 0x039E). With any other device number selected, reads of 0x30, 0x60 to 0x63 and 0x70 return 0xFF, and writes to them change no output.
- R9: A banked write affects only the bank of the currently selected device. Every other bank keeps its values.
- R10: `io_rdata` takes its new value on the clock edge that samples `io_rd`. A read of an address outside the port pair returns 0xFF. With the window open, a read of an index that has no register returns 0x00.
- R11: While open, a read of the index port returns the stored index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | IO_AW | I/O address of the current cycle |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | 8 | Read data, registered |
| dev_active | output | NSLOT | Activate bit of each device |
| dev_base0 | output | NSLOT*16 | Base address 0 of each device |
| dev_base1 | output | NSLOT*16 | Base address 1 of each device |
| dev_irq | output | NSLOT*8 | Interrupt select of each device |

## Verification
The bench programs two implemented devices with different activate, base and interrupt values. It then reads each value back and compares the output buses, which separates correct banking from writes that land in the wrong bank or leak into other banks. An activate write of 0xFE shows whether bit 0 alone is stored. An unimplemented device below the slot count and a device number above the slot count are tried to expose missing all-ones handling. Data-port traffic while locked, followed by reading back the stored index after re-entry, shows whether locked writes and the exit key leak into the registers.

// File: rtl/pnpcfg_pkg.sv
package pnpcfg_pkg;

    localparam int BASE_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [0:0] {
        CFG_LOCKED = 1'b0,
        CFG_OPEN   = 1'b1
    } cfg_state_e;

    localparam logic [BYTE_W-1:0] KEY_ENTER = 8'h55;
    localparam logic [BYTE_W-1:0] KEY_EXIT  = 8'hAA;
    localparam logic [BYTE_W-1:0] IDX_LDN   = 8'h07;
    localparam logic [BYTE_W-1:0] IDX_ACT   = 8'h30;
    localparam logic [BYTE_W-1:0] IDX_B0H   = 8'h60;
    localparam logic [BYTE_W-1:0] IDX_B0L   = 8'h61;
    localparam logic [BYTE_W-1:0] IDX_B1H   = 8'h62;
    localparam logic [BYTE_W-1:0] IDX_B1L   = 8'h63;
    localparam logic [BYTE_W-1:0] IDX_IRQ   = 8'h70;
    localparam logic [BYTE_W-1:0] RD_FLOAT  = 8'hFF;

endpackage

// File: rtl/pnpcfg_keyfsm.sv
module pnpcfg_keyfsm
    import pnpcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic              open,
    output logic              idx_load
);

    cfg_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_LOCKED: if (idx_wr && wdata == KEY_ENTER) state_d = CFG_OPEN;
            CFG_OPEN:   if (idx_wr && wdata == KEY_EXIT)  state_d = CFG_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CFG_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        open     = (state_q == CFG_OPEN);
        idx_load = open && idx_wr && (wdata != KEY_EXIT);
    end

    // R2: the entry key opens the window
    a_r2_enter_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (!open && idx_wr && wdata == KEY_ENTER) |=> open);

    // R2: the exit key locks the window
    a_r2_exit_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (open && idx_wr && wdata == KEY_EXIT) |=> !open);

    // R3: other index writes while locked keep the window locked
    a_r3_locked_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!open && !(idx_wr && wdata == KEY_ENTER)) |=> !open);

endmodule

// File: rtl/pnpcfg_bank.sv
module pnpcfg_bank
    import pnpcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] reg_idx,
    input  logic [BYTE_W-1:0] wdata,
    output logic              active,
    output logic [BASE_W-1:0] base0,
    output logic [BASE_W-1:0] base1,
    output logic [BYTE_W-1:0] irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            base0  <= '0;
            base1  <= '0;
            irq    <= '0;
        end else if (wr_en) begin
            case (reg_idx)
                IDX_ACT: active        <= wdata[0];
                IDX_B0H: base0[15:8]   <= wdata;
                IDX_B0L: base0[7:0]    <= wdata;
                IDX_B1H: base1[15:8]   <= wdata;
                IDX_B1L: base1[7:0]    <= wdata;
                IDX_IRQ: irq           <= wdata;
                default: ;
            endcase
        end
    end

    // R9: a bank that is not written keeps all its values
    a_r9_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({active, base0, base1, irq}));

    // R5: an activate write stores data bit 0
    a_r5_act_store: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_idx == IDX_ACT) |=> (active == $past(wdata[0])));

endmodule

// File: rtl/pnpcfg_port.sv
module pnpcfg_port
    import pnpcfg_pkg::*;
#(
    parameter int               IO_AW     = 16,
    parameter logic [IO_AW-1:0] PORT_BASE = 'h2E,
    parameter int               NSLOT     = 16,
    parameter logic [NSLOT-1:0] IMPL_MASK = 'h039E
)(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IO_AW-1:0]        io_addr,
    input  logic [BYTE_W-1:0]       io_wdata,
    input  logic                    io_wr,
    input  logic                    io_rd,
    output logic [BYTE_W-1:0]       io_rdata,
    output logic [NSLOT-1:0]        dev_active,
    output logic [NSLOT*BASE_W-1:0] dev_base0,
    output logic [NSLOT*BASE_W-1:0] dev_base1,
    output logic [NSLOT*BYTE_W-1:0] dev_irq
);

    localparam int               SLOT_W    = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam logic [IO_AW-1:0] PORT_DATA = PORT_BASE + IO_AW'(1);

    logic              hit_idx, hit_dat;
    logic              open, idx_load, dat_wr;
    logic [BYTE_W-1:0] idx_q, ldn_q;
    logic [SLOT_W-1:0] ldn_sel;
    logic              slot_ok;
    logic [BYTE_W-1:0] rd_mux;

    assign hit_idx = (io_addr == PORT_BASE);
    assign hit_dat = (io_addr == PORT_DATA);
    assign dat_wr  = io_wr && hit_dat && open;
    assign ldn_sel = ldn_q[SLOT_W-1:0];
    assign slot_ok = (32'(ldn_q) < NSLOT) && IMPL_MASK[ldn_sel];

    pnpcfg_keyfsm u_keyfsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (io_wr && hit_idx),
        .wdata    (io_wdata),
        .open     (open),
        .idx_load (idx_load)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            ldn_q <= '0;
        end else begin
            if (idx_load) idx_q <= io_wdata;
            if (dat_wr && idx_q == IDX_LDN) ldn_q <= io_wdata;
        end
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        if (IMPL_MASK[g]) begin : g_bank
            logic bank_wr;
            assign bank_wr = dat_wr && slot_ok && (ldn_sel == SLOT_W'(g));
            pnpcfg_bank u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (bank_wr),
                .reg_idx (idx_q),
                .wdata   (io_wdata),
                .active  (dev_active[g]),
                .base0   (dev_base0[g*BASE_W +: BASE_W]),
                .base1   (dev_base1[g*BASE_W +: BASE_W]),
                .irq     (dev_irq[g*BYTE_W +: BYTE_W])
            );
        end else begin : g_empty
            assign dev_active[g]                 = 1'b0;
            assign dev_base0[g*BASE_W +: BASE_W] = '0;
            assign dev_base1[g*BASE_W +: BASE_W] = '0;
            assign dev_irq[g*BYTE_W +: BYTE_W]   = '0;
        end
    end

    always_comb begin
        if (!(hit_idx || hit_dat) || !open) begin
            rd_mux = RD_FLOAT;
        end else if (hit_idx) begin
            rd_mux = idx_q;
        end else begin
            unique case (idx_q)
                IDX_LDN: rd_mux = ldn_q;
                IDX_ACT: rd_mux = slot_ok ? {7'b0, dev_active[ldn_sel]} : RD_FLOAT;
                IDX_B0H: rd_mux = slot_ok ? dev_base0[ldn_sel*BASE_W + 8 +: 8] : RD_FLOAT;
                IDX_B0L: rd_mux = slot_ok ? dev_base0[ldn_sel*BASE_W +: 8] : RD_FLOAT;
                IDX_B1H: rd_mux = slot_ok ? dev_base1[ldn_sel*BASE_W + 8 +: 8] : RD_FLOAT;
                IDX_B1L: rd_mux = slot_ok ? dev_base1[ldn_sel*BASE_W +: 8] : RD_FLOAT;
                IDX_IRQ: rd_mux = slot_ok ? dev_irq[ldn_sel*BYTE_W +: BYTE_W] : RD_FLOAT;
                default: rd_mux = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     io_rdata <= RD_FLOAT;
        else if (io_rd) io_rdata <= rd_mux;
    end

    // R3: data-port reads while locked return all ones
    a_r3_locked_read: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && hit_dat && !open) |=> (io_rdata == RD_FLOAT));

    // R8: activate read of a device without a bank returns all ones
    a_r8_unimpl_read: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && hit_dat && open && idx_q == IDX_ACT && !slot_ok) |=> (io_rdata == RD_FLOAT));

    // R10: reads outside the port pair return all ones
    a_r10_outside_read: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !hit_idx && !hit_dat) |=> (io_rdata == RD_FLOAT));

    // R3: locked cycles leave every exported bank value unchanged
    a_r3_locked_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !open |=> $stable({dev_active, dev_base0, dev_base1, dev_irq}));

    // R10: read data changes only on a sampled read strobe
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> $stable(io_rdata));

endmodule

// File: tb/test_pnpcfg_port.sv
module test_pnpcfg_port;

    localparam logic [15:0] P_IDX = 16'h002E;
    localparam logic [15:0] P_DAT = 16'h002F;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [15:0]  io_addr = '0;
    logic [7:0]   io_wdata = '0;
    logic         io_wr = 1'b0;
    logic         io_rd = 1'b0;
    logic [7:0]   io_rdata;
    logic [15:0]  dev_active;
    logic [255:0] dev_base0;
    logic [255:0] dev_base1;
    logic [127:0] dev_irq;

    int vectors = 0;
    int errors  = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [15:0] act_exp = '0;

    always #5 clk = ~clk;

    pnpcfg_port i_pnpcfg_port (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
        .dev_active(dev_active), .dev_base0(dev_base0),
        .dev_base1(dev_base1), .dev_irq(dev_irq)
    );

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic cfg(input logic [7:0] idx, input logic [7:0] d);
        io_write(P_IDX, idx);
        io_write(P_DAT, d);
    endtask

    task automatic cfg_rd(input logic [7:0] idx, input logic [7:0] e, input string tag);
        io_write(P_IDX, idx);
        io_read(P_DAT, e, tag);
    endtask

    task automatic check_out(input logic [31:0] act, input logic [31:0] e, input string tag);
        vectors++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, e);
        end
    endtask

    // monitor: compare each read against the scoreboard queue
    initial begin
        forever begin
            @(posedge clk);
            if (io_rd) begin
                @(negedge clk);
                vectors++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL scoreboard: read with no expected item, got %h expected none", io_rdata);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (io_rdata !== e) begin
                        errors++;
                        $display("FAIL %s: got %h expected %h", t, io_rdata, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_out({16'h0, dev_active}, 32'h0, "R1 active after reset");
        check_out({31'h0, |{dev_base0, dev_base1, dev_irq}}, 32'h0, "R1 banks zero after reset");
        // R3 locked reads
        io_read(P_DAT, 8'hFF, "R3 locked data read");
        io_read(P_IDX, 8'hFF, "R3 locked index read");
        // R3 locked writes ignored
        io_write(P_IDX, 8'h07);
        io_write(P_DAT, 8'h04);
        // R2 enter key
        io_write(P_IDX, 8'h55);
        io_read(P_IDX, 8'h00, "R3 locked index write ignored");
        cfg_rd(8'h07, 8'h00, "R3 locked data write ignored");
        // R4 device number
        cfg(8'h07, 8'h04);
        io_read(P_DAT, 8'h04, "R4 device number readback");
        io_read(P_IDX, 8'h07, "R11 index readback");
        // R5 activate
        cfg(8'h30, 8'h01);
        act_exp[4] = 1'b1;
        io_read(P_DAT, 8'h01, "R5 activate readback");
        check_out({16'h0, dev_active}, {16'h0, act_exp}, "R5 dev_active");
        // R6 base addresses
        cfg(8'h60, 8'h03);
        cfg(8'h61, 8'hF8);
        cfg(8'h62, 8'h12);
        cfg(8'h63, 8'h34);
        cfg_rd(8'h60, 8'h03, "R6 base0 high");
        cfg_rd(8'h61, 8'hF8, "R6 base0 low");
        cfg_rd(8'h63, 8'h34, "R6 base1 low");
        check_out({16'h0, dev_base0[4*16 +: 16]}, 32'h03F8, "R6 dev_base0 slot4");
        check_out({16'h0, dev_base1[4*16 +: 16]}, 32'h1234, "R6 dev_base1 slot4");
        // R7 interrupt select
        cfg(8'h70, 8'h04);
        io_read(P_DAT, 8'h04, "R7 irq readback");
        check_out({24'h0, dev_irq[4*8 +: 8]}, 32'h04, "R7 dev_irq slot4");
        // R9 second device
        cfg(8'h07, 8'h02);
        cfg(8'h30, 8'hFE);
        io_read(P_DAT, 8'h00, "R5 only bit0 stored");
        cfg(8'h30, 8'h03);
        act_exp[2] = 1'b1;
        io_read(P_DAT, 8'h01, "R5 activate slot2");
        cfg(8'h60, 8'h00);
        cfg(8'h61, 8'h62);
        cfg(8'h70, 8'h0B);
        check_out({16'h0, dev_base0[2*16 +: 16]}, 32'h0062, "R9 dev_base0 slot2");
        check_out({16'h0, dev_base0[4*16 +: 16]}, 32'h03F8, "R9 slot4 base0 kept");
        check_out({24'h0, dev_irq[4*8 +: 8]}, 32'h04, "R9 slot4 irq kept");
        check_out({16'h0, dev_active}, {16'h0, act_exp}, "R9 dev_active two devices");
        // R8 unimplemented devices
        cfg(8'h07, 8'h05);
        cfg(8'h30, 8'h01);
        cfg(8'h70, 8'h09);
        io_read(P_DAT, 8'hFF, "R8 unimplemented irq read");
        cfg_rd(8'h30, 8'hFF, "R8 unimplemented activate read");
        check_out({16'h0, dev_active}, {16'h0, act_exp}, "R8 write ignored");
        check_out({24'h0, dev_irq[5*8 +: 8]}, 32'h00, "R8 slot5 irq unchanged");
        cfg(8'h07, 8'h24);
        cfg_rd(8'h30, 8'hFF, "R8 device above slot count");
        cfg_rd(8'h61, 8'hFF, "R8 base read above slot count");
        // R10 undefined index and foreign address
        cfg_rd(8'h40, 8'h00, "R10 undefined index");
        io_read(16'h0080, 8'hFF, "R10 outside port pair");
        // deactivate device 4
        cfg(8'h07, 8'h04);
        cfg(8'h30, 8'h00);
        act_exp[4] = 1'b0;
        check_out({16'h0, dev_active}, {16'h0, act_exp}, "R5 deactivate");
        // R2 exit key, then locked writes
        io_write(P_IDX, 8'h30);
        io_write(P_IDX, 8'hAA);
        io_read(P_DAT, 8'hFF, "R2 exit locks");
        io_write(P_DAT, 8'h01);
        check_out({16'h0, dev_active}, {16'h0, act_exp}, "R3 locked write no effect");
        io_write(P_IDX, 8'h55);
        io_read(P_IDX, 8'h30, "R2 exit key not stored as index");
        io_read(P_DAT, 8'h00, "R3 activate still cleared");
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule